// File: doc/BRIEF.md
# Program-Memory Conflict Instruction Cache

The cache sits beside the instruction sequencer of a core in which instruction fetches and data accesses share one program-memory bus. When a data transfer takes that bus in the same cycle as an instruction fetch, the fetch loses the bus. The sequencer stalls for one cycle, and the instruction word delivered for that fetch address is written into a 32-entry fully associative store. Later fetches of that address are served from the store, so a colliding data access no longer costs a cycle.

Lookup is combinational, so a hit is reported and its word is driven in the cycle of the fetch. Only conflict misses allocate. An ordinary miss never allocates, and fetches from external spaces never touch the store because separate caches serve them. Replacement fills the lowest-numbered free slot first. Once every slot holds a valid entry, the least recently used entry is replaced. Software-side controls can disable the cache, freeze it for inspection, or invalidate every entry in a single cycle.

Top module: `ccache_top`

## Requirements
- R1: After reset no entry is valid, and with `cache_off_i`, `freeze_i` and `inval_i` all low the cache is in service. The first conflicting fetch therefore stalls and does not hit.
- R2: `hit_o` is high in the same cycle as a fetch (`fetch_valid_i`=1, `fetch_ext_i`=0, `cache_off_i`=0) whose address equals the tag of a valid entry. In that cycle `instr_o` carries the stored word. In every other cycle `instr_o` equals `mem_instr_i`.
- R3: `stall_o` is high exactly in a cycle with an internal fetch, `pm_conflict_i`=1 and no hit. A conflict that hits does not stall.
- R4: A conflict miss (not frozen, not disabled, no invalidate) writes one entry at the end of that cycle with `fetch_addr_i` as tag and `mem_instr_i` as data. A miss without conflict allocates nothing, and a later fetch of that address still misses.
- R5: A fetch with `fetch_ext_i`=1 never hits, never stalls and never allocates.
- R6: The fill slot is the lowest-indexed invalid entry. When all entries are valid, the fill slot is the least recently used entry, where a hit or a fill counts as a use.
- R7: While `freeze_i`=1 nothing is allocated and recency is not updated, but lookups still hit.
- R8: While `cache_off_i`=1 every lookup misses, every conflicting internal fetch stalls, and neither contents nor recency change.
- R9: `inval_i`=1 clears every valid bit at the next edge. It takes precedence over a fill and a recency update in the same cycle.
- R10: The store holds 32 entries (`ENTRIES`). Any 32 distinct addresses filled by conflicts all hit afterwards, and a 33rd fill evicts exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | A fetch is presented this cycle |
| fetch_addr_i | input | AW | Fetch address |
| fetch_ext_i | input | 1 | Fetch targets an external space |
| mem_instr_i | input | IW | Instruction word from program memory for the fetch address |
| pm_conflict_i | input | 1 | A data access owns the program-memory bus this cycle |
| cache_off_i | input | 1 | Disable: all lookups miss, no updates |
| freeze_i | input | 1 | Hold contents and recency, keep serving hits |
| inval_i | input | 1 | Invalidate all entries at the next edge |
| instr_o | output | IW | Instruction word to decode |
| hit_o | output | 1 | Fetch served from the cache |
| stall_o | output | 1 | Fetch stall request |

## Verification
The bench fills all 32 slots, touches a subset, and then forces a 33rd fill. A design whose recency order is wrong evicts a recently used address, and that address then misses and stalls. The bench issues an ordinary miss and later a conflict at the same address. A design that allocates on every miss hits too early at that point. The bench checks that a frozen or disabled cache keeps serving or refusing hits while its contents stay unchanged. It also puts a conflict miss and an invalidate in the same cycle, which exposes a design that lets the fill survive. External fetches made while the target address is cached check that such fetches bypass the store.

// File: rtl/ccache_pkg.sv
package ccache_pkg;
  localparam int unsigned DEF_ENTRIES = 32;
  localparam int unsigned DEF_AW      = 20;
  localparam int unsigned DEF_IW      = 48;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_HIT   = 2'd1,
    LK_MISS  = 2'd2,
    LK_STALL = 2'd3
  } lookup_e;
endpackage

// File: rtl/ccache_lookup.sv
module ccache_lookup #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 20,
  localparam int unsigned IDXW = $clog2(N)
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] tags_i,
  input  logic [AW-1:0]        addr_i,
  output logic                 hit_o,
  output logic [IDXW-1:0]      idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == addr_i);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i] && !hit_o) begin
        hit_o = 1'b1;
        idx_o = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/ccache_lru.sv
module ccache_lru #(
  parameter int unsigned N = 32,
  localparam int unsigned IDXW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            touch_i,
  input  logic [IDXW-1:0] touch_idx_i,
  input  logic [N-1:0]    valid_i,
  output logic [IDXW-1:0] victim_o
);
  // age 0 = most recent; ages always form a permutation of 0..N-1
  logic [N-1:0][IDXW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDXW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDXW'(i) == touch_idx_i)           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] && !found) begin
        found    = 1'b1;
        victim_o = IDXW'(i);
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == IDXW'(N-1)) victim_o = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/ccache_store.sv
module ccache_store #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 20,
  parameter int unsigned IW = 48,
  localparam int unsigned IDXW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 inval_i,
  input  logic                 we_i,
  input  logic [IDXW-1:0]      widx_i,
  input  logic [AW-1:0]        waddr_i,
  input  logic [IW-1:0]        wdata_i,
  output logic [N-1:0]         valid_o,
  output logic [N-1:0][AW-1:0] tags_o,
  output logic [N-1:0][IW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       valid_o <= '0;
    else if (inval_i)  valid_o <= '0;
    else if (we_i)     valid_o[widx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i && !inval_i) begin
      tags_o[widx_i] <= waddr_i;
      data_o[widx_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/ccache_top.sv
module ccache_top
  import ccache_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned AW      = DEF_AW,
  parameter int unsigned IW      = DEF_IW,
  localparam int unsigned IDXW   = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          fetch_ext_i,
  input  logic [IW-1:0] mem_instr_i,
  input  logic          pm_conflict_i,
  input  logic          cache_off_i,
  input  logic          freeze_i,
  input  logic          inval_i,
  output logic [IW-1:0] instr_o,
  output logic          hit_o,
  output logic          stall_o
);
  logic [ENTRIES-1:0]         valid_q;
  logic [ENTRIES-1:0][AW-1:0] tags_q;
  logic [ENTRIES-1:0][IW-1:0] data_q;
  logic                       raw_hit;
  logic [IDXW-1:0]            hit_idx, victim_idx;
  logic                       upd_ok, fill, touch;
  lookup_e                    outcome;

  ccache_lookup #(.N(ENTRIES), .AW(AW)) u_lookup (
    .valid_i(valid_q), .tags_i(tags_q), .addr_i(fetch_addr_i),
    .hit_o(raw_hit), .idx_o(hit_idx)
  );

  always_comb begin
    if (!fetch_valid_i || fetch_ext_i)  outcome = LK_IDLE;
    else if (!cache_off_i && raw_hit)   outcome = LK_HIT;
    else if (pm_conflict_i)             outcome = LK_STALL;
    else                                outcome = LK_MISS;
  end

  assign hit_o   = (outcome == LK_HIT);
  assign stall_o = (outcome == LK_STALL);
  assign instr_o = hit_o ? data_q[hit_idx] : mem_instr_i;

  // updates need an enabled internal lookup, no freeze, no invalidate
  assign upd_ok = (outcome != LK_IDLE) && !cache_off_i && !freeze_i && !inval_i;
  assign fill   = upd_ok && (outcome == LK_STALL);
  assign touch  = upd_ok && (outcome != LK_MISS);

  ccache_lru #(.N(ENTRIES)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch),
    .touch_idx_i(hit_o ? hit_idx : victim_idx),
    .valid_i(valid_q), .victim_o(victim_idx)
  );

  ccache_store #(.N(ENTRIES), .AW(AW), .IW(IW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .inval_i(inval_i), .we_i(fill),
    .widx_i(victim_idx), .waddr_i(fetch_addr_i), .wdata_i(mem_instr_i),
    .valid_o(valid_q), .tags_o(tags_q), .data_o(data_q)
  );
endmodule

// File: rtl/ccache_chk.sv
module ccache_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         fetch_valid_i,
  input logic         fetch_ext_i,
  input logic         pm_conflict_i,
  input logic         cache_off_i,
  input logic         freeze_i,
  input logic         inval_i,
  input logic         hit_o,
  input logic         stall_o,
  input logic [N-1:0] valid_q
);
  AST_HIT_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !stall_o); // R3
  AST_STALL_NEEDS_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (pm_conflict_i && fetch_valid_i)); // R3
  AST_EXT_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ext_i |-> (!hit_o && !stall_o)); // R5
  AST_OFF_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_off_i |-> !hit_o); // R8
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_off_i && !inval_i) |=> $stable(valid_q)); // R8
  AST_FREEZE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !inval_i) |=> $stable(valid_q)); // R7
  AST_INVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (valid_q == '0)); // R9
  AST_GROW_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(valid_q) > $countones($past(valid_q))) |-> $past(stall_o)); // R4
endmodule

bind ccache_top ccache_chk #(.N(ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_valid_i(fetch_valid_i),
  .fetch_ext_i(fetch_ext_i), .pm_conflict_i(pm_conflict_i),
  .cache_off_i(cache_off_i), .freeze_i(freeze_i), .inval_i(inval_i),
  .hit_o(hit_o), .stall_o(stall_o), .valid_q(valid_q)
);

// File: tb/ccache_top_test.sv
module ccache_top_test;
  localparam int N  = 32;
  localparam int AW = 20;
  localparam int IW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fv = 1'b0, ext = 1'b0, conf = 1'b0, off = 1'b0, frz = 1'b0, inv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [IW-1:0] mem = '0;
  logic [IW-1:0] instr;
  logic hit, stall;

  int vectors = 0;
  int errors  = 0;

  // bench model
  logic          m_valid [N];
  logic [AW-1:0] m_tag   [N];
  logic [IW-1:0] m_data  [N];
  int            m_age   [N];

  always #10 clk = ~clk;

  ccache_top uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_addr_i(addr),
    .fetch_ext_i(ext), .mem_instr_i(mem), .pm_conflict_i(conf),
    .cache_off_i(off), .freeze_i(frz), .inval_i(inv),
    .instr_o(instr), .hit_o(hit), .stall_o(stall)
  );

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic int victim();
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    for (int i = 0; i < N; i++) if (m_age[i] == N-1) return i;
    return 0;
  endfunction

  function automatic void touch(int k);
    int ak = m_age[k];
    for (int j = 0; j < N; j++) if (m_age[j] < ak) m_age[j]++;
    m_age[k] = 0;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_age[i] = i; m_tag[i] = '0; m_data[i] = '0;
    end
  endfunction

  task automatic chk(string tag, string what, logic [IW-1:0] act, logic [IW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before posedge, advance model
  task automatic step(logic v, logic [AW-1:0] a, logic e, logic [IW-1:0] d,
                      logic c, logic o, logic f, logic iv, string tag);
    int idx, vic;
    logic ehit, estall;
    logic [IW-1:0] einstr;
    @(negedge clk);
    fv = v; addr = a; ext = e; mem = d; conf = c; off = o; frz = f; inv = iv;
    #2;
    idx    = find(a);
    ehit   = v && !e && !o && (idx >= 0);
    estall = v && !e && c && !ehit;
    einstr = ehit ? m_data[idx] : d;
    chk(tag, "hit", IW'(hit), IW'(ehit));
    chk(tag, "stall", IW'(stall), IW'(estall));
    chk(tag, "instr", instr, einstr);
    if (iv) begin
      for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    end else if (v && !e && !o && !f) begin
      if (ehit) touch(idx);
      else if (c) begin
        vic = victim();
        m_valid[vic] = 1'b1; m_tag[vic] = a; m_data[vic] = d;
        touch(vic);
      end
    end
  endtask

  function automatic logic [IW-1:0] word(logic [AW-1:0] a);
    return {a, 8'h5a, a} ^ IW'(48'h1234_0000_0000);
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset, conflicting fetch stalls
    step(1, 20'h00100, 0, word(20'h00100), 1, 0, 0, 0, "R1");
    step(1, 20'h00100, 0, word(20'h00100), 1, 0, 0, 0, "R2");   // now hits, no stall (R3)
    step(1, 20'h00100, 0, 48'hdead, 0, 0, 0, 0, "R2");
    // R4: plain miss does not allocate
    step(1, 20'h00200, 0, word(20'h00200), 0, 0, 0, 0, "R4");
    step(1, 20'h00200, 0, word(20'h00200), 1, 0, 0, 0, "R4");
    step(1, 20'h00200, 0, 48'h0, 1, 0, 0, 0, "R3");
    // R5: external fetch of cached address bypasses
    step(1, 20'h00100, 1, 48'h777, 1, 0, 0, 0, "R5");
    step(1, 20'h00300, 1, 48'h778, 1, 0, 0, 0, "R5");
    step(1, 20'h00300, 0, word(20'h00300), 0, 0, 0, 0, "R5");
    // R7: frozen - hits kept, no fill
    step(1, 20'h00400, 0, word(20'h00400), 1, 0, 1, 0, "R7");
    step(1, 20'h00100, 0, 48'h1, 1, 0, 1, 0, "R7");
    step(1, 20'h00400, 0, word(20'h00400), 1, 0, 0, 0, "R7");
    // R8: disabled - misses, no fill
    step(1, 20'h00100, 0, 48'h2, 1, 1, 0, 0, "R8");
    step(1, 20'h00500, 0, word(20'h00500), 1, 1, 0, 0, "R8");
    step(1, 20'h00500, 0, word(20'h00500), 0, 0, 0, 0, "R8");
    // R9: invalidate beats a fill in same cycle
    step(1, 20'h00600, 0, word(20'h00600), 1, 0, 0, 1, "R9");
    step(1, 20'h00100, 0, 48'h3, 0, 0, 0, 0, "R9");
    step(1, 20'h00600, 0, 48'h4, 0, 0, 0, 0, "R9");

    // R10 / R6: fill all slots, touch some, force eviction
    for (int i = 0; i < N; i++)
      step(1, AW'(20'h01000 + i), 0, word(AW'(20'h01000 + i)), 1, 0, 0, 0, "R10");
    for (int i = 0; i < N; i++)
      step(1, AW'(20'h01000 + i), 0, 48'h0, 1, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++)
      step(1, AW'(20'h01000 + i), 0, 48'h0, 0, 0, 0, 0, "R6");
    step(1, 20'h02000, 0, word(20'h02000), 1, 0, 0, 0, "R6");   // evicts 0x01004
    step(1, 20'h01004, 0, word(20'h01004), 0, 0, 0, 0, "R6");
    step(1, 20'h01000, 0, 48'h0, 0, 0, 0, 0, "R6");
    step(1, 20'h02000, 0, 48'h0, 0, 0, 0, 0, "R6");

    // random mix checked against the model
    for (int n = 0; n < 5000; n++) begin
      logic [AW-1:0] a;
      a = AW'(20'h03000 + $urandom_range(0, 44));
      step($urandom_range(0, 9) != 0, a, $urandom_range(0, 19) == 0,
           {$urandom, $urandom} , $urandom_range(0, 9) < 4,
           $urandom_range(0, 29) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 199) == 0, "R2 R3 R4 R6");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule